// File: doc/BRIEF.md
# Split Transfer Shift-Clock Inserter

Video memories that perform a split shift-register transfer need one extra shift-clock edge while the display is blanked. This block produces that edge. It runs from a fast oversampling clock. It passes the normal shift clock through, with that clock forced low while blanking is active. It watches an asynchronous transfer flag, and when the flag rises under the right conditions it ORs a single pulse of fixed width into the outgoing shift clock.

The pulse is armed only when software has set the split-transfer enable and cleared the nibble-packing mode. The flag is brought into the clock domain through a synchronizer. A low-to-high step of the synchronized flag, seen while blanking is asserted, launches exactly one pulse. The flag has to go low and rise again before a second pulse can be produced. At the default 200 MHz clock the pulse starts within 20 ns of the flag edge and stays high for 15 ns.

Top module: `sclk_split_inserter`

## Requirements
- R1: After reset, `ins_pulse` is 0 and `sclk_out` follows `sclk_in & blank_n`.
- R2: A flag high sampled at clock edge k, after a low sample at edge k-1, raises `ins_pulse` after edge k+SYNC_STAGES (k+2 by default). With 5 ns cycles this is within 4 cycles (20 ns) of the flag edge.
- R3: Each inserted pulse is high for exactly PULSE_CYCLES consecutive cycles (3 by default, 15 ns).
- R4: No pulse is produced while `split_en` is 0.
- R5: No pulse is produced while `nibble_mode` is 1.
- R6: A flag edge detected while `blank_n` is 1 (blanking inactive) is ignored and arms nothing.
- R7: Holding the flag high produces only one pulse.
- R8: A new flag edge detected while a pulse is still running is dropped. It neither extends the pulse nor queues another.
- R9: `sclk_out` is high whenever `ins_pulse` is high. Otherwise it equals `sclk_in` when `blank_n` is 1 and is 0 when `blank_n` is 0.
- R10: Once the flag has returned low and a pulse has ended, a new rising edge produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock (200 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_flag | input | 1 | Asynchronous split-transfer request flag |
| blank_n | input | 1 | Blanking, active low |
| split_en | input | 1 | Split-transfer enable control bit |
| nibble_mode | input | 1 | Nibble-packing mode control bit; 1 blocks insertion |
| sclk_in | input | 1 | Normal shift clock |
| sclk_out | output | 1 | Shift clock with blanking gate and inserted pulse |
| ins_pulse | output | 1 | High while the inserted pulse is driven |

## Verification
The bench targets the edge detector, using a flag held high for many cycles and a flag that falls and rises again in the middle of a pulse. A detector that is level-sensitive would emit repeated pulses in the first case. A design that reloads its counter would stretch the pulse in the second case. Each qualifier (enable, nibble mode, blanking) is toggled on its own, so a design that drops any one of them would show a pulse where none is allowed. Start latency and width are measured cycle by cycle, which catches an extra synchronizer stage or an off-by-one counter. The pass-through path is checked with blanking both on and off, which catches a missing or inverted gate.

// File: rtl/sclk_split_inserter.sv
module sclk_split_inserter #(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_flag,
  input  logic blank_n,
  input  logic split_en,
  input  logic nibble_mode,
  input  logic sclk_in,
  output logic sclk_out,
  output logic ins_pulse
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);

  logic [SYNC_STAGES:0] flag_q;
  logic [CW-1:0]        cnt_q;
  logic                 edge_seen, busy, fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= '0;
    else        flag_q <= {flag_q[SYNC_STAGES-1:0], xfer_flag};

  assign edge_seen = flag_q[SYNC_STAGES-1] & ~flag_q[SYNC_STAGES];
  assign busy      = cnt_q != '0;
  assign fire      = edge_seen & split_en & ~nibble_mode & ~blank_n & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    cnt_q <= '0;
    else if (fire) cnt_q <= CW'(PULSE_CYCLES);
    else if (busy) cnt_q <= cnt_q - CW'(1);

  assign ins_pulse = busy;
  assign sclk_out  = (sclk_in & blank_n) | ins_pulse;
endmodule

module sclk_split_inserter_chk #(
  parameter int SYNC_STAGES  = 2,
  parameter int PULSE_CYCLES = 3
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_flag,
  input logic blank_n,
  input logic split_en,
  input logic nibble_mode,
  input logic sclk_in,
  input logic sclk_out,
  input logic ins_pulse
);
  localparam int RW = $clog2(PULSE_CYCLES + 2) + 1;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                       run_q <= '0;
    else if (!ins_pulse)              run_q <= '0;
    else if (run_q <= RW'(PULSE_CYCLES)) run_q <= run_q + RW'(1);

  assert_start_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_pulse) |-> $past(xfer_flag, SYNC_STAGES + 1) && !$past(xfer_flag, SYNC_STAGES + 2));

  assert_width_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ins_pulse) |-> run_q == RW'(PULSE_CYCLES));

  assert_width_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(PULSE_CYCLES));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_pulse) |-> $past(split_en));

  assert_nibble_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_pulse) |-> !$past(nibble_mode));

  assert_blank_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_pulse) |-> !$past(blank_n));

  assert_pulse_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ins_pulse |-> sclk_out);

  assert_blank_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!blank_n && !ins_pulse) |-> !sclk_out);
endmodule

bind sclk_split_inserter sclk_split_inserter_chk #(
  .SYNC_STAGES(SYNC_STAGES),
  .PULSE_CYCLES(PULSE_CYCLES)
) i_chk (.*);

// File: tb/test_sclk_split_inserter.sv
module test_sclk_split_inserter;
  logic clk = 0, rst_n = 0;
  logic xfer_flag = 0, blank_n = 1, split_en = 0, nibble_mode = 0, sclk_in = 0;
  logic sclk_out, ins_pulse;
  int   n_tests = 0, n_fail = 0;
  bit   done = 0;

  always #2.5 clk = ~clk;

  sclk_split_inserter i_sclk_split_inserter (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pat[i] is driven before posedge i; samples are taken at the following negedge
  task automatic drive_pat(input logic [15:0] pat, output int first, output int highs,
                           output int runs, output int out_mism);
    logic prev = 0;
    first = -1; highs = 0; runs = 0; out_mism = 0;
    for (int i = 0; i < 24; i++) begin
      xfer_flag = (i < 16) ? pat[i] : 1'b0;
      @(negedge clk);
      if (ins_pulse) begin
        highs++;
        if (first < 0) first = i;
        if (!prev) runs++;
      end
      if (sclk_out !== ins_pulse) out_mism++;
      prev = ins_pulse;
    end
  endtask

  task automatic t_reset;
    blank_n = 1; sclk_in = 1;
    #1;
    check("R1", "pulse in reset", int'(ins_pulse), 0);
    check("R1", "sclk_out in reset", int'(sclk_out), 1);
    sclk_in = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    check("R1", "pulse after reset", int'(ins_pulse), 0);
  endtask

  task automatic t_basic;
    int f, h, r, m;
    split_en = 1; nibble_mode = 0; blank_n = 0; sclk_in = 0;
    drive_pat(16'h0001, f, h, r, m);
    check("R2", "start cycle", f, 2);
    check("R3", "width", h, 3);
    check("R9", "sclk_out vs pulse", m, 0);
  endtask

  task automatic t_disabled;
    int f, h, r, m;
    split_en = 0; nibble_mode = 0; blank_n = 0;
    drive_pat(16'h0001, f, h, r, m);
    check("R4", "pulses with enable off", h, 0);
    check("R4", "sclk_out with enable off", m, 0);
    split_en = 1;
  endtask

  task automatic t_nibble;
    int f, h, r, m;
    nibble_mode = 1; blank_n = 0;
    drive_pat(16'h0001, f, h, r, m);
    check("R5", "pulses in nibble mode", h, 0);
    nibble_mode = 0;
  endtask

  task automatic t_blank_off;
    int f, h, r, m;
    blank_n = 1; sclk_in = 0;
    drive_pat(16'h0001, f, h, r, m);
    check("R6", "pulses outside blanking", h, 0);
    check("R6", "sclk_out outside blanking", m, 0);
    blank_n = 0;
  endtask

  task automatic t_hold;
    int f, h, r, m;
    drive_pat(16'hFFFF, f, h, r, m);
    check("R7", "runs for held flag", r, 1);
    check("R7", "width for held flag", h, 3);
  endtask

  task automatic t_retrigger;
    int f, h, r, m;
    drive_pat(16'b101, f, h, r, m);
    check("R8", "runs with mid-pulse edge", r, 1);
    check("R8", "width with mid-pulse edge", h, 3);
  endtask

  task automatic t_rearm;
    int f, h, r, m;
    drive_pat(16'b1_0000_0001, f, h, r, m);
    check("R10", "runs after rearm", r, 2);
    check("R10", "total high cycles", h, 6);
    check("R10", "first start", f, 2);
  endtask

  task automatic t_merge;
    int bad = 0;
    blank_n = 1;
    for (int i = 0; i < 8; i++) begin
      sclk_in = i[0];
      @(negedge clk);
      if (sclk_out !== sclk_in) bad++;
    end
    check("R9", "pass-through mismatches", bad, 0);
    blank_n = 0; bad = 0;
    for (int i = 0; i < 8; i++) begin
      sclk_in = ~i[0];
      @(negedge clk);
      if (sclk_out !== 1'b0) bad++;
    end
    check("R9", "gated mismatches", bad, 0);
    sclk_in = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_disabled();
    t_nibble();
    t_blank_off();
    t_hold();
    t_retrigger();
    t_rearm();
    t_merge();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule